// File: doc/BRIEF.md
# Four-Phase Bundled-Data Stage Controller

This block is a clocked model of the control unit that sits around one processing stage of a self-timed pipeline that uses bundled data. An upstream producer offers an item with a request wire plus a data bus. The controller latches the operand, raises a start strobe to the datapath and waits for a done indication. A counter models the matched delay: it produces done a fixed number of cycles after start. The controller then captures the datapath result and offers it downstream with its own request wire. After the downstream consumer acknowledges, the controller acknowledges upstream.

Every request and acknowledge wire returns to zero for each item. The return half runs in the same order as the forward half: upstream request drops, start drops, done drops once the modelled delay has elapsed, the downstream request drops, the downstream acknowledge drops and, last, the upstream acknowledge drops. A sticky flag records handshake edges that arrive in an illegal order.

Top module: `hsk_stage_ctrl`

## Requirements
- R1: While `rst` is high and after it is released, `in_ack`, `dp_start`, `dp_done`, `out_req` and `proto_err` are all low and the controller is idle.
- R2: When idle and `in_req` is high at a clock edge, `dp_start` is high after that edge and `dp_operand` holds the `in_data` value sampled there.
- R3: `dp_done` rises exactly DELAY clock edges after `dp_start` rises, and falls exactly DELAY edges after `dp_start` falls (default DELAY = 3).
- R4: `out_req` rises on the edge after the one that raised `dp_done`. On that same edge `out_data` captures `dp_result`.
- R5: `in_ack` stays low while `out_ack` is low during an item, and rises on the edge after `out_ack` is seen high.
- R6: `dp_start` falls on the edge after `in_req` is seen low while `in_ack` is high.
- R7: `out_req` stays high until `dp_done` has fallen, and falls on the edge after `dp_done` is seen low.
- R8: `in_ack` falls on the edge after `out_ack` is seen low with `out_req` low. The controller is then idle and accepts the next item.
- R9: `out_data` changes only on the edge where `out_req` rises. It holds its value through the whole return phase, even when `dp_result` changes.
- R10: Changes on `in_data` while the controller is not accepting an item have no effect on `dp_operand`.
- R11: `proto_err` is set and stays set until reset if any of these occurs: `in_req` falls while `in_ack` is low, `in_req` rises while `in_ack` is high, `out_ack` rises while `out_req` is low, or `out_ack` falls while `out_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_req | input | 1 | Upstream request (data valid) |
| in_data | input | W | Upstream bundled data |
| in_ack | output | 1 | Upstream acknowledge |
| dp_operand | output | W | Latched operand presented to the datapath |
| dp_start | output | 1 | Start strobe to the datapath |
| dp_result | input | W | Datapath result |
| dp_done | output | 1 | Completion from the matched-delay model |
| out_req | output | 1 | Downstream request (data valid) |
| out_data | output | W | Registered result offered downstream |
| out_ack | input | 1 | Downstream acknowledge |
| proto_err | output | 1 | Sticky handshake ordering error |

## Verification
The ordering assertions assume that both neighbours obey the return-to-zero handshake. Upstream holds `in_data` while `in_req` is high, and each acknowledge changes only after the matching request has changed. Reset is held for at least two cycles. The bench drives every input at the falling clock edge and waits for each controller output edge before it makes the next move. The only exceptions are the error tests, which break the order on purpose and are then cleared by reset.

// File: rtl/hsk_pkg.sv
package hsk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_EVAL  = 3'd1,
    ST_SEND  = 3'd2,
    ST_ACKED = 3'd3,
    ST_RTZ   = 3'd4,
    ST_DRAIN = 3'd5
  } stage_st_e;
endpackage

// File: rtl/hsk_delay_model.sv
module hsk_delay_model #(
  parameter int unsigned DELAY = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic done
);
  localparam int unsigned CW = (DELAY > 1) ? $clog2(DELAY) : 1;
  localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (start != done) begin
      if (cnt == LAST) begin
        done <= start;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      cnt <= '0;
    end
  end

  // R3: done only moves after start has disagreed with it
  p_done_moves_r3: assert property (@(posedge clk) disable iff (rst)
    (done != $past(done)) |-> ($past(start) != $past(done)));

  // R3: done never rises while start is low
  p_done_rise_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> start);
endmodule

// File: rtl/hsk_data_hold.sv
module hsk_data_hold #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/hsk_order_mon.sv
module hsk_order_mon (
  input  logic clk,
  input  logic rst,
  input  logic in_req,
  input  logic out_ack,
  input  logic in_ack,
  input  logic out_req,
  output logic err
);
  logic in_req_q, out_ack_q;
  logic viol;

  always_comb begin
    viol = 1'b0;
    if (in_req_q && !in_req && !in_ack)   viol = 1'b1;
    if (!in_req_q && in_req && in_ack)    viol = 1'b1;
    if (!out_ack_q && out_ack && !out_req) viol = 1'b1;
    if (out_ack_q && !out_ack && out_req)  viol = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_req_q  <= 1'b0;
      out_ack_q <= 1'b0;
      err       <= 1'b0;
    end else begin
      in_req_q  <= in_req;
      out_ack_q <= out_ack;
      err       <= err | viol;
    end
  end

  // R11: once set, the flag stays until reset
  p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    $past(err) |-> err);
endmodule

// File: rtl/hsk_stage_ctrl.sv
module hsk_stage_ctrl
  import hsk_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter int unsigned DELAY = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_req,
  input  logic [W-1:0] in_data,
  output logic         in_ack,
  output logic [W-1:0] dp_operand,
  output logic         dp_start,
  input  logic [W-1:0] dp_result,
  output logic         dp_done,
  output logic         out_req,
  output logic [W-1:0] out_data,
  input  logic         out_ack,
  output logic         proto_err
);
  stage_st_e state;
  logic      op_load, res_load;

  assign op_load  = (state == ST_IDLE) && in_req;
  assign res_load = (state == ST_EVAL) && dp_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      dp_start <= 1'b0;
      out_req  <= 1'b0;
      in_ack   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE:  if (in_req)   begin dp_start <= 1'b1; state <= ST_EVAL;  end
        ST_EVAL:  if (dp_done)  begin out_req  <= 1'b1; state <= ST_SEND;  end
        ST_SEND:  if (out_ack)  begin in_ack   <= 1'b1; state <= ST_ACKED; end
        ST_ACKED: if (!in_req)  begin dp_start <= 1'b0; state <= ST_RTZ;   end
        ST_RTZ:   if (!dp_done) begin out_req  <= 1'b0; state <= ST_DRAIN; end
        ST_DRAIN: if (!out_ack) begin in_ack   <= 1'b0; state <= ST_IDLE;  end
        default:  state <= ST_IDLE;
      endcase
    end
  end

  hsk_data_hold #(.W(W)) u_op_hold (
    .clk(clk), .rst(rst), .load(op_load), .d(in_data), .q(dp_operand)
  );

  hsk_data_hold #(.W(W)) u_res_hold (
    .clk(clk), .rst(rst), .load(res_load), .d(dp_result), .q(out_data)
  );

  hsk_delay_model #(.DELAY(DELAY)) u_delay (
    .clk(clk), .rst(rst), .start(dp_start), .done(dp_done)
  );

  hsk_order_mon u_mon (
    .clk(clk), .rst(rst), .in_req(in_req), .out_ack(out_ack),
    .in_ack(in_ack), .out_req(out_req), .err(proto_err)
  );

  p_start_rise_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(dp_start) |-> $past(in_req));

  p_outreq_rise_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(out_req) |-> $past(dp_done));

  p_inack_rise_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(in_ack) |-> $past(out_ack) && out_req);

  p_start_fall_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(dp_start) |-> ($past(!in_req) && in_ack));

  p_outreq_fall_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(out_req) |-> $past(!dp_done));

  p_inack_fall_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(in_ack) |-> ($past(!out_ack) && !out_req));

  p_out_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (out_data != $past(out_data)) |-> $rose(out_req));
endmodule

// File: tb/hsk_stage_ctrl_tb.sv
module hsk_stage_ctrl_tb;
  localparam int unsigned W     = 8;
  localparam int unsigned DELAY = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_req = 1'b0;
  logic [W-1:0] in_data = '0;
  logic in_ack, dp_start, dp_done, out_req, proto_err;
  logic [W-1:0] dp_operand, dp_result, out_data;
  logic out_ack = 1'b0;
  logic corrupt = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  assign dp_result = corrupt ? 8'hEE : (dp_operand * 8'd3 + 8'd5);

  hsk_stage_ctrl #(.W(W), .DELAY(DELAY)) u_dut (
    .clk(clk), .rst(rst), .in_req(in_req), .in_data(in_data), .in_ack(in_ack),
    .dp_operand(dp_operand), .dp_start(dp_start), .dp_result(dp_result),
    .dp_done(dp_done), .out_req(out_req), .out_data(out_data),
    .out_ack(out_ack), .proto_err(proto_err)
  );

  // {input operand, expected result = 3*x+5 mod 256}
  localparam logic [15:0] VECS [6] = '{
    16'h0005, 16'h0108, 16'h5504, 16'hFF02, 16'h8085, 16'h2A83
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_req = 1'b0; out_ack = 1'b0; corrupt = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_item(input logic [W-1:0] din, input logic [W-1:0] exp);
    @(negedge clk);
    in_data = din; in_req = 1'b1;
    @(negedge clk);
    chk("R2 start", dp_start, 1);
    chk("R2 operand", dp_operand, din);
    repeat (DELAY - 1) @(negedge clk);
    chk("R3 done early", dp_done, 0);
    @(negedge clk);
    chk("R3 done rise", dp_done, 1);
    chk("R4 outreq waits", out_req, 0);
    @(negedge clk);
    chk("R4 outreq", out_req, 1);
    chk("R4 outdata", out_data, exp);
    repeat (2) @(negedge clk);
    chk("R5 no ack yet", in_ack, 0);
    out_ack = 1'b1;
    @(negedge clk);
    chk("R5 inack", in_ack, 1);
    in_req = 1'b0; in_data = din ^ 8'h5A; corrupt = 1'b1;
    @(negedge clk);
    chk("R6 start fall", dp_start, 0);
    chk("R10 operand kept", dp_operand, din);
    repeat (DELAY - 1) @(negedge clk);
    chk("R3 done held", dp_done, 1);
    chk("R7 outreq held", out_req, 1);
    @(negedge clk);
    chk("R3 done fall", dp_done, 0);
    chk("R7 outreq still", out_req, 1);
    @(negedge clk);
    chk("R7 outreq fall", out_req, 0);
    chk("R9 outdata held", out_data, exp);
    chk("R8 inack held", in_ack, 1);
    out_ack = 1'b0;
    @(negedge clk);
    chk("R8 inack fall", in_ack, 0);
    chk("R9 outdata after", out_data, exp);
    corrupt = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset inack", in_ack, 0);
    chk("R1 reset outreq", out_req, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle start", dp_start, 0);
    chk("R1 idle done", dp_done, 0);
    chk("R1 idle err", proto_err, 0);

    for (int i = 0; i < 6; i++) begin
      run_item(VECS[i][15:8], VECS[i][7:0]);
      chk("R11 no err", proto_err, 0);
    end

    // R10: idle glitches on in_data leave the operand unchanged
    @(negedge clk); in_data = 8'h11;
    @(negedge clk); in_data = 8'hC3;
    @(negedge clk);
    chk("R10 idle glitch", dp_operand, VECS[5][15:8]);
    chk("R8 still idle", dp_start, 0);

    // R11: out_ack rising without out_req
    do_reset();
    chk("R1 after reset err", proto_err, 0);
    out_ack = 1'b1;
    @(negedge clk);
    chk("R11 stray ack", proto_err, 1);
    out_ack = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 sticky", proto_err, 1);

    // R1: reset clears flag and handshake outputs
    do_reset();
    @(negedge clk);
    chk("R1 err cleared", proto_err, 0);
    chk("R1 outreq low", out_req, 0);

    // R11: in_req withdrawn before in_ack
    in_data = 8'h07; in_req = 1'b1;
    @(negedge clk);
    in_req = 1'b0;
    @(negedge clk);
    chk("R11 early withdraw", proto_err, 1);

    do_reset();
    @(negedge clk);
    chk("R1 final err", proto_err, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule